// File: doc/BRIEF.md
# Biphasic Stimulation Pulse Sequencer

This block is the digital controller of an eight-channel constant-current neural stimulator. A fast free-running oscillator clocks it. An integer divider derives a slower local clock enable from that oscillator, and a coarser timing unit of about 10 µs. A demodulated on-off-keyed downlink bit passes through one flip-flop that is enabled by the local clock. It is then shifted in one bit per local clock period. Each frame opens with a fixed synchronisation byte. Its payload selects a channel, a current amplitude, an interphase-gap option, a per-phase width and a repetition period.

From the active configuration the block produces stimulation events. Each event drives one electrode switch and consists of a cathodic phase, an optional fixed gap with every switch open, and an anodic phase of the same length. A direction output selects the current polarity, and a 4-bit amplitude code goes to the external current DAC. Width and period codes are clamped into their allowed ranges. A newly received configuration waits in a staging register and is adopted only when the next event starts.

Top module: `stim_sequencer`

## Requirements
- R1: After reset, all switch enables, the direction output and the amplitude code are 0, and no event occurs until a valid frame has been received.
- R2: `lclk_en` is high for exactly one `clk` cycle in every DIV cycles. One time unit is DIV*UNIT_DIV `clk` cycles.
- R3: A frame is 34 bits, sent most significant bit first, one bit per `lclk_en`. The bits are: sync byte 0xA5, then channel[2:0], amplitude[3:0], gap enable, width code[7:0] and period code[9:0]. A frame whose first byte is not 0xA5 is ignored.
- R4: During both phases, exactly one bit of `sw_en` is high, and it is bit number channel. At every other time `sw_en` is 0.
- R5: The cathodic phase (`dir`=0, switch closed) lasts width units and is followed by the anodic phase (`dir`=1) of the same length. `dir` is 0 whenever no switch is closed.
- R6: `dac_code` equals the programmed amplitude throughout both phases of an event and is 0 outside them.
- R7: With gap enable set, the two phases are separated by 2 units during which every switch is open. With gap enable clear, the anodic phase follows the cathodic phase on the next cycle.
- R8: Width codes below 5 act as 5, and codes above 100 act as 100.
- R9: Successive events start period*PER_SCALE units apart. Period codes below 5 act as 5, and codes above 1000 act as 1000.
- R10: If an event lasts as long as or longer than its period, the next event starts one unit after the anodic phase ends.
- R11: A configuration received during an event does not alter that event. It is first used by the next event, and the interval up to that event uses the old period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| dl_in | input | 1 | Demodulated downlink bit |
| lclk_en | output | 1 | Divided local clock enable |
| sw_en | output | 8 | Per-electrode switch enables |
| dir | output | 1 | Current direction, 1 during the anodic phase |
| dac_code | output | 4 | Amplitude code to the current DAC |

## Verification
The properties assume only that reset is applied before the first event. The downlink bit may take any value at any time, because it is registered before use. The properties also rely on width clamping and on the one-unit idle slot, which keep the end of one event from touching the start of the next. The bench changes `dl_in` only just after a falling edge at which `lclk_en` is high, so each bit stays stable for a whole local clock period around its sampling edge. Events are measured in `clk` cycles against width, gap and period values worked out from the frame fields.

// File: rtl/stim_pkg.sv
package stim_pkg;

    localparam int NCH       = 8;
    localparam int CH_W      = 3;
    localparam int AMP_W     = 4;
    localparam int WCODE_W   = 8;
    localparam int PCODE_W   = 10;
    localparam int SYNC_W    = 8;
    localparam logic [SYNC_W-1:0] SYNC_WORD = 8'hA5;
    localparam int PAYLOAD_W = CH_W + AMP_W + 1 + WCODE_W + PCODE_W;
    localparam int FRAME_W   = SYNC_W + PAYLOAD_W;

    localparam int WIDTH_MIN  = 5;
    localparam int WIDTH_MAX  = 100;
    localparam int PERIOD_MIN = 5;
    localparam int PERIOD_MAX = 1000;
    localparam int GAP_UNITS  = 2;

    typedef struct packed {
        logic [CH_W-1:0]    chan;
        logic [AMP_W-1:0]   amp;
        logic               gap_en;
        logic [WCODE_W-1:0] width;
        logic [PCODE_W-1:0] period;
    } stim_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CATH = 2'd1,
        PH_GAP  = 2'd2,
        PH_ANOD = 2'd3
    } phase_t;

    function automatic logic [WCODE_W-1:0] clamp_width(input logic [WCODE_W-1:0] c);
        if (c < WCODE_W'(WIDTH_MIN)) return WCODE_W'(WIDTH_MIN);
        if (c > WCODE_W'(WIDTH_MAX)) return WCODE_W'(WIDTH_MAX);
        return c;
    endfunction

    function automatic logic [PCODE_W-1:0] clamp_period(input logic [PCODE_W-1:0] c);
        if (c < PCODE_W'(PERIOD_MIN)) return PCODE_W'(PERIOD_MIN);
        if (c > PCODE_W'(PERIOD_MAX)) return PCODE_W'(PERIOD_MAX);
        return c;
    endfunction

    function automatic stim_cfg_t decode_payload(input logic [PAYLOAD_W-1:0] p);
        stim_cfg_t c;
        c        = stim_cfg_t'(p);
        c.width  = clamp_width(c.width);
        c.period = clamp_period(c.period);
        return c;
    endfunction

endpackage

// File: rtl/stim_clkdiv.sv
module stim_clkdiv #(
    parameter int DIV      = 11,
    parameter int UNIT_DIV = 11
) (
    input  logic clk,
    input  logic rst,
    output logic lclk_en,
    output logic unit_tick
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int UW = (UNIT_DIV > 2) ? $clog2(UNIT_DIV) : 1;

    logic [DW-1:0] dcnt;
    logic [UW-1:0] ucnt;

    assign lclk_en   = (dcnt == DW'(DIV - 1));
    assign unit_tick = lclk_en && (ucnt == UW'(UNIT_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt <= '0;
            ucnt <= '0;
        end else begin
            if (lclk_en) dcnt <= '0;
            else         dcnt <= dcnt + 1'b1;
            if (lclk_en) begin
                if (ucnt == UW'(UNIT_DIV - 1)) ucnt <= '0;
                else                           ucnt <= ucnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/stim_deframer.sv
module stim_deframer
    import stim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lclk_en,
    input  logic      dl_in,
    output logic      cfg_valid,
    output stim_cfg_t cfg
);
    logic               bit_q;
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] shreg_nx;
    logic               sync_hit;

    assign shreg_nx = {shreg[FRAME_W-2:0], bit_q};
    assign sync_hit = (shreg_nx[FRAME_W-1 -: SYNC_W] == SYNC_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q     <= 1'b0;
            shreg     <= '0;
            cfg_valid <= 1'b0;
            cfg       <= '0;
        end else begin
            cfg_valid <= 1'b0;
            if (lclk_en) begin
                bit_q <= dl_in;
                if (sync_hit) begin
                    shreg     <= '0;
                    cfg_valid <= 1'b1;
                    cfg       <= decode_payload(shreg_nx[PAYLOAD_W-1:0]);
                end else begin
                    shreg <= shreg_nx;
                end
            end
        end
    end
endmodule

// File: rtl/stim_phase_seq.sv
module stim_phase_seq
    import stim_pkg::*;
#(
    parameter int PER_SCALE = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             unit_tick,
    input  logic             cfg_valid,
    input  stim_cfg_t        cfg,
    output logic [NCH-1:0]   sw_en,
    output logic             dir,
    output logic [AMP_W-1:0] dac_code
);
    localparam int PU_W = $clog2(PERIOD_MAX * PER_SCALE + 1);

    stim_cfg_t          pend;
    stim_cfg_t          act;
    logic               have_cfg;
    phase_t             phase;
    logic [WCODE_W-1:0] wcnt;
    logic [PU_W-1:0]    pcnt;
    logic [PU_W-1:0]    per_units;
    logic               period_up;
    logic               start_ev;
    logic               in_pulse;
    logic               w_last;

    assign per_units = PU_W'(act.period) * PU_W'(PER_SCALE);
    assign period_up = ({1'b0, pcnt} + (PU_W+1)'(1)) >= {1'b0, per_units};
    assign start_ev  = unit_tick && (phase == PH_IDLE) && have_cfg && period_up;
    assign w_last    = (wcnt == act.width - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            have_cfg <= 1'b0;
        end else if (cfg_valid) begin
            pend     <= cfg;
            have_cfg <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act   <= '0;
            phase <= PH_IDLE;
            wcnt  <= '0;
            pcnt  <= '1;
        end else if (unit_tick) begin
            if (start_ev) begin
                act   <= pend;
                phase <= PH_CATH;
                wcnt  <= '0;
                pcnt  <= '0;
            end else begin
                if (pcnt != '1) pcnt <= pcnt + 1'b1;
                unique case (phase)
                    PH_IDLE: wcnt <= '0;
                    PH_CATH: begin
                        if (w_last) begin
                            wcnt  <= '0;
                            phase <= act.gap_en ? PH_GAP : PH_ANOD;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                    PH_GAP: begin
                        if (wcnt == WCODE_W'(GAP_UNITS - 1)) begin
                            wcnt  <= '0;
                            phase <= PH_ANOD;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                    PH_ANOD: begin
                        if (w_last) begin
                            wcnt  <= '0;
                            phase <= PH_IDLE;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign in_pulse = (phase == PH_CATH) || (phase == PH_ANOD);
    assign dir      = (phase == PH_ANOD);
    assign dac_code = in_pulse ? act.amp : '0;

    for (genvar i = 0; i < NCH; i++) begin : g_sw
        assign sw_en[i] = in_pulse && (act.chan == CH_W'(i));
    end
endmodule

// File: rtl/stim_sequencer.sv
module stim_sequencer
    import stim_pkg::*;
#(
    parameter int DIV       = 11,
    parameter int UNIT_DIV  = 11,
    parameter int PER_SCALE = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dl_in,
    output logic             lclk_en,
    output logic [NCH-1:0]   sw_en,
    output logic             dir,
    output logic [AMP_W-1:0] dac_code
);
    logic      unit_tick;
    logic      cfg_valid;
    stim_cfg_t cfg;

    stim_clkdiv #(.DIV(DIV), .UNIT_DIV(UNIT_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .lclk_en   (lclk_en),
        .unit_tick (unit_tick)
    );

    stim_deframer u_rx (
        .clk       (clk),
        .rst       (rst),
        .lclk_en   (lclk_en),
        .dl_in     (dl_in),
        .cfg_valid (cfg_valid),
        .cfg       (cfg)
    );

    stim_phase_seq #(.PER_SCALE(PER_SCALE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .unit_tick (unit_tick),
        .cfg_valid (cfg_valid),
        .cfg       (cfg),
        .sw_en     (sw_en),
        .dir       (dir),
        .dac_code  (dac_code)
    );
endmodule

// File: rtl/stim_sequencer_chk.sv
module stim_sequencer_chk
    import stim_pkg::*;
#(
    parameter int DIV = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             lclk_en,
    input logic [NCH-1:0]   sw_en,
    input logic             dir,
    input logic [AMP_W-1:0] dac_code
);
    // R2: the local enable never lasts two cycles
    a_r2_en_single: assert property (@(posedge clk) disable iff (rst)
        (DIV > 1 && lclk_en) |=> !lclk_en);

    // R4: never more than one electrode switch closed
    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sw_en));

    // R4: the electrode does not change while a phase continues
    a_r4_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (sw_en != '0 && $past(sw_en) != '0) |-> (sw_en == $past(sw_en)));

    // R5: direction asserted only with a switch closed
    a_r5_dir_gated: assert property (@(posedge clk) disable iff (rst)
        dir |-> (sw_en != '0));

    // R5: anodic phase never returns to cathodic without an idle cycle
    a_r5_no_reverse: assert property (@(posedge clk) disable iff (rst)
        ($past(dir) && sw_en != '0) |-> dir);

    // R6: amplitude code is zero when no switch is closed
    a_r6_dac_idle: assert property (@(posedge clk) disable iff (rst)
        (sw_en == '0) |-> (dac_code == '0));

    // R6: amplitude stays constant within a phase
    a_r6_dac_hold: assert property (@(posedge clk) disable iff (rst)
        (sw_en != '0 && $past(sw_en) != '0) |-> $stable(dac_code));
endmodule

bind stim_sequencer stim_sequencer_chk #(.DIV(DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lclk_en  (lclk_en),
    .sw_en    (sw_en),
    .dir      (dir),
    .dac_code (dac_code)
);

// File: tb/sim_stim_sequencer.sv
module sim_stim_sequencer;
    localparam int DIV       = 2;
    localparam int UNIT_DIV  = 2;
    localparam int PER_SCALE = 4;
    localparam int UNIT      = DIV * UNIT_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dl_in = 1'b0;
    logic       lclk_en;
    logic [7:0] sw_en;
    logic       dir;
    logic [3:0] dac_code;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stim_sequencer #(.DIV(DIV), .UNIT_DIV(UNIT_DIV), .PER_SCALE(PER_SCALE)) u0 (
        .clk(clk), .rst(rst), .dl_in(dl_in), .lclk_en(lclk_en),
        .sw_en(sw_en), .dir(dir), .dac_code(dac_code)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        dl_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_lclk();
        do @(negedge clk); while (!lclk_en);
    endtask

    task automatic send_frame(input logic [7:0] sy, input logic [2:0] ch,
                              input logic [3:0] amp, input logic gap,
                              input logic [7:0] w, input logic [9:0] p);
        logic [33:0] fr;
        fr = {sy, ch, amp, gap, w, p};
        for (int i = 33; i >= 0; i--) begin
            wait_lclk();
            dl_in = fr[i];
        end
        wait_lclk();
        dl_in = 1'b0;
    endtask

    task automatic measure_event(input int ch, input int amp, input int wu,
                                 input int gu, input string tag, output longint t0);
        int lim = 0;
        int nc = 0;
        int ng = 0;
        int na = 0;
        int bad = 0;
        t0 = 0;
        while (sw_en == 8'd0 && lim < 40000) begin
            @(negedge clk);
            lim++;
        end
        chk(lim < 40000, tag, "event start seen", lim, 0);
        if (lim >= 40000) return;
        t0 = cyc;
        while (sw_en != 8'd0 && !dir) begin
            if (sw_en != (8'd1 << ch) || dac_code != 4'(amp)) bad++;
            nc++;
            @(negedge clk);
        end
        while (sw_en == 8'd0 && ng < 1000) begin
            if (dir || dac_code != 4'd0) bad++;
            ng++;
            @(negedge clk);
        end
        while (sw_en != 8'd0 && dir) begin
            if (sw_en != (8'd1 << ch) || dac_code != 4'(amp)) bad++;
            na++;
            @(negedge clk);
        end
        chk(nc == wu * UNIT, tag, "cathodic cycles", nc, wu * UNIT);
        chk(ng == gu * UNIT, tag, "interphase cycles", ng, gu * UNIT);
        chk(na == wu * UNIT, tag, "anodic cycles", na, wu * UNIT);
        chk(bad == 0, tag, "switch/amplitude mismatches", bad, 0);
        chk(sw_en == 8'd0 && !dir && dac_code == 4'd0, tag, "idle after event", sw_en, 0);
    endtask

    // R1, R2
    task automatic t_reset();
        int act_cnt = 0;
        int gap = 0;
        do_reset();
        @(negedge clk);
        chk(sw_en == 8'd0, "R1", "sw_en after reset", sw_en, 0);
        chk(dir == 1'b0, "R1", "dir after reset", dir, 0);
        chk(dac_code == 4'd0, "R1", "dac_code after reset", dac_code, 0);
        wait_lclk();
        do begin
            @(negedge clk);
            gap++;
        end while (!lclk_en && gap < 100);
        chk(gap == DIV, "R2", "lclk_en spacing", gap, DIV);
        repeat (300) begin
            @(negedge clk);
            if (sw_en != 8'd0 || dir || dac_code != 4'd0) act_cnt++;
        end
        chk(act_cnt == 0, "R1", "activity without frame", act_cnt, 0);
    endtask

    // R3 R4 R5 R6 R9
    task automatic t_basic();
        longint s1, s2;
        do_reset();
        send_frame(8'hA5, 3'd3, 4'd9, 1'b0, 8'd10, 10'd20);
        measure_event(3, 9, 10, 0, "R3 R4 R5 R6", s1);
        measure_event(3, 9, 10, 0, "R4 R5 R6", s2);
        chk(s2 - s1 == 20 * PER_SCALE * UNIT, "R9", "period cycles", s2 - s1,
            20 * PER_SCALE * UNIT);
    endtask

    // R7
    task automatic t_gap();
        longint s;
        do_reset();
        send_frame(8'hA5, 3'd6, 4'd5, 1'b1, 8'd7, 10'd20);
        measure_event(6, 5, 7, 2, "R7", s);
    endtask

    // R8 R9 lower clamps
    task automatic t_clamp_low();
        longint s1, s2;
        do_reset();
        send_frame(8'hA5, 3'd0, 4'd1, 1'b0, 8'd2, 10'd0);
        measure_event(0, 1, 5, 0, "R8", s1);
        measure_event(0, 1, 5, 0, "R8", s2);
        chk(s2 - s1 == 5 * PER_SCALE * UNIT, "R9", "clamped low period", s2 - s1,
            5 * PER_SCALE * UNIT);
    endtask

    // R8 R9 upper clamps
    task automatic t_clamp_high();
        longint s1, s2;
        do_reset();
        send_frame(8'hA5, 3'd7, 4'd15, 1'b0, 8'd200, 10'd1023);
        measure_event(7, 15, 100, 0, "R8", s1);
        measure_event(7, 15, 100, 0, "R8", s2);
        chk(s2 - s1 == 1000 * PER_SCALE * UNIT, "R9", "clamped high period", s2 - s1,
            1000 * PER_SCALE * UNIT);
    endtask

    // R10
    task automatic t_overrun();
        longint s1, s2;
        do_reset();
        send_frame(8'hA5, 3'd1, 4'd3, 1'b1, 8'd50, 10'd5);
        measure_event(1, 3, 50, 2, "R10", s1);
        measure_event(1, 3, 50, 2, "R10", s2);
        chk(s2 - s1 == (2 * 50 + 2 + 1) * UNIT, "R10", "overrun restart", s2 - s1,
            (2 * 50 + 2 + 1) * UNIT);
    endtask

    // R3 wrong sync byte
    task automatic t_badsync();
        int act_cnt = 0;
        longint s;
        do_reset();
        send_frame(8'h5A, 3'd7, 4'd15, 1'b1, 8'hFF, 10'h3FF);
        repeat (2000) begin
            @(negedge clk);
            if (sw_en != 8'd0) act_cnt++;
        end
        chk(act_cnt == 0, "R3", "activity after bad sync", act_cnt, 0);
        send_frame(8'hA5, 3'd2, 4'd6, 1'b0, 8'd5, 10'd10);
        measure_event(2, 6, 5, 0, "R3", s);
    endtask

    // R11
    task automatic t_defer();
        longint sa, sb;
        do_reset();
        send_frame(8'hA5, 3'd2, 4'd4, 1'b0, 8'd40, 10'd50);
        fork
            begin
                while (sw_en == 8'd0) @(negedge clk);
                send_frame(8'hA5, 3'd5, 4'd11, 1'b1, 8'd8, 10'd20);
            end
            measure_event(2, 4, 40, 0, "R11", sa);
        join
        measure_event(5, 11, 8, 2, "R11", sb);
        chk(sb - sa == 50 * PER_SCALE * UNIT, "R11", "interval uses old period", sb - sa,
            50 * PER_SCALE * UNIT);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_gap();
        t_clamp_low();
        t_clamp_high();
        t_overrun();
        t_badsync();
        t_defer();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule